// File: doc/BRIEF.md
# Queue-Mapped Register Operand Unit

This block is the operand store on the execute side of a decoupled access/execute processor. Instructions name their sources and destination with 5-bit operand codes. Thirty-one of those codes select ordinary registers. The all-ones code does not select a register. It selects a pair of architectural FIFO queues. When an instruction reads that code, it takes the oldest word that the access side has delivered for loading, and that word leaves the queue. When an instruction writes that code, it places the result at the tail of the store-data queue, and the memory side drains it from there.

Each issue presents two source codes, each with its own use flag, and a destination code with a write flag and write data. The unit returns both source operands in the same cycle. It raises `stall` without a clock edge when the issue cannot go ahead: the load queue holds fewer words than the sources need, or the store queue is full and the instruction writes the queue code. A stalled issue changes no issue-side state. The access side fills the load queue through a push port. Memory empties the store queue through a pop port. Both of these ports keep working while issue is stalled.

Top module: `queue_operand_regfile`

## Requirements
- R1: A synchronous reset clears all 31 ordinary registers to zero and empties both queues, so `stValid` and `ldFull` are low after reset.
- R2: A register code 0 to 30 reads that register's current value. A write with `wrEn` takes effect at the clock edge. A read of the same register in the same cycle returns the old value.
- R3: A source set to code 31 returns the oldest load-queue word and removes it when the issue proceeds. Every delivered word is read exactly once, in the order it was delivered.
- R4: When both sources use code 31, source A receives the oldest word and source B the next oldest, and both words are removed.
- R5: `stall` is high when the enabled sources using code 31 need more words than the load queue holds: one word for one such source, two words for two.
- R6: A proceeding issue with `wrEn` and destination code 31 appends `wrData` to the store queue. `stData` shows the oldest entry while `stValid` is high. The entry is removed at a clock edge with `stPopReady` high.
- R7: `stall` is high when `wrEn` is set, the destination is code 31, and the store queue already holds 8 entries.
- R8: In a stalled cycle no register is written, no load word is removed and no store entry is added.
- R9: The load queue holds 8 words. `ldFull` is high at 8 words, and a push offered while full is dropped.
- R10: `stall` is low whenever `issueValid` is low. Without `issueValid`, no register or queue changes on behalf of the issue side.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| issueValid | input | 1 | An instruction requests issue this cycle |
| srcAEn | input | 1 | Source A operand is used |
| srcACode | input | 5 | Source A operand code |
| srcBEn | input | 1 | Source B operand is used |
| srcBCode | input | 5 | Source B operand code |
| wrEn | input | 1 | The instruction writes its destination |
| dstCode | input | 5 | Destination operand code |
| wrData | input | 32 | Result to write |
| stall | output | 1 | Issue cannot proceed this cycle |
| srcAData | output | 32 | Source A operand value |
| srcBData | output | 32 | Source B operand value |
| ldPushValid | input | 1 | Access side offers a load word |
| ldPushData | input | 32 | Load word offered |
| ldFull | output | 1 | Load queue holds 8 words |
| stPopReady | input | 1 | Memory takes the store head at this edge |
| stValid | output | 1 | Store queue is not empty |
| stData | output | 32 | Oldest store entry |

## Verification
The bench goes after the cases where issue and queue traffic meet. One case is both sources reading code 31 while the load queue holds exactly one word. A design that checks only for an empty queue would let that issue through and hand source B a stale word. Another case is a store-queue push offered at 8 entries while memory pops in the same cycle. A design that ignores the full flag would overwrite the head. Stalled issues that also carry a register write are checked by reading the register back afterwards, which catches a write enable that is not gated by the stall. Same-cycle read and write of one register catches an unwanted bypass. A cycle-accurate model in the bench tracks all 31 registers and both queues through thousands of mixed random cycles, so a lost, duplicated or reordered queue word shows up as a data mismatch.

// File: rtl/qorf_pkg.sv
package qorf_pkg;

  // Strobes passed from the issue control to the datapath
  typedef struct packed {
    logic [1:0] ldPopCnt;  // load words removed at this edge (0..2)
    logic       srcAQ;     // source A reads the load queue
    logic       srcBQ;     // source B reads the load queue
    logic       stPush;    // append wrData to store queue
    logic       regWrite;  // write wrData into register dstCode
  } opStrobes_t;

endpackage

// File: rtl/qorf_fifo.sv
module qorf_fifo #(
  parameter int DW    = 32,
  parameter int DEPTH = 8
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         pushEn,
  input  logic [DW-1:0]                pushData,
  input  logic [1:0]                   popCnt,
  output logic [DW-1:0]                headData,
  output logic [DW-1:0]                nextData,
  output logic [$clog2(DEPTH+1)-1:0]   count,
  output logic                         full,
  output logic                         empty
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH+1);

  logic [DW-1:0]    mem [DEPTH];
  logic [PTR_W-1:0] rdPtr;
  logic [PTR_W-1:0] wrPtr;

  function automatic logic [PTR_W-1:0] wrapAdd(input logic [PTR_W-1:0] p, input int inc);
    int sum;
    sum = int'(p) + inc;
    if (sum >= DEPTH) sum = sum - DEPTH;
    return PTR_W'(sum);
  endfunction

  assign headData = mem[rdPtr];
  assign nextData = mem[wrapAdd(rdPtr, 1)];
  assign full     = (count == CNT_W'(DEPTH));
  assign empty    = (count == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      rdPtr <= '0;
      wrPtr <= '0;
      count <= '0;
    end else begin
      if (pushEn) begin
        mem[wrPtr] <= pushData;
        wrPtr      <= wrapAdd(wrPtr, 1);
      end
      rdPtr <= wrapAdd(rdPtr, int'(popCnt));
      count <= count + CNT_W'(pushEn) - CNT_W'(popCnt);
    end
  end
endmodule

// File: rtl/qorf_ctrl.sv
module qorf_ctrl
  import qorf_pkg::*;
#(
  parameter int CODE_W = 5,
  parameter int CNT_W  = 4,
  parameter int DEPTH  = 8
) (
  input  logic              issueValid,
  input  logic              srcAEn,
  input  logic [CODE_W-1:0] srcACode,
  input  logic              srcBEn,
  input  logic [CODE_W-1:0] srcBCode,
  input  logic              wrEn,
  input  logic [CODE_W-1:0] dstCode,
  input  logic [CNT_W-1:0]  ldCount,
  input  logic              stFull,
  output logic              stall,
  output opStrobes_t        strobes
);
  localparam logic [CODE_W-1:0] QCODE = '1;

  logic       aQ, bQ, dQ, go;
  logic [1:0] needLd;
  logic       ldShort, stBlock;

  always_comb begin
    aQ      = srcAEn && (srcACode == QCODE);
    bQ      = srcBEn && (srcBCode == QCODE);
    dQ      = wrEn && (dstCode == QCODE);
    needLd  = {1'b0, aQ} + {1'b0, bQ};
    ldShort = CNT_W'(needLd) > ldCount;
    stBlock = dQ && stFull;
    stall   = issueValid && (ldShort || stBlock);
    go      = issueValid && !stall;

    strobes.srcAQ    = aQ;
    strobes.srcBQ    = bQ;
    strobes.ldPopCnt = go ? needLd : 2'd0;
    strobes.stPush   = go && dQ;
    strobes.regWrite = go && wrEn && !dQ;
  end
endmodule

// File: rtl/qorf_datapath.sv
module qorf_datapath
  import qorf_pkg::*;
#(
  parameter int DW     = 32,
  parameter int CODE_W = 5,
  parameter int DEPTH  = 8
) (
  input  logic                       clk,
  input  logic                       rst,
  input  opStrobes_t                 strobes,
  input  logic [CODE_W-1:0]          srcACode,
  input  logic [CODE_W-1:0]          srcBCode,
  input  logic [CODE_W-1:0]          dstCode,
  input  logic [DW-1:0]              wrData,
  output logic [DW-1:0]              srcAData,
  output logic [DW-1:0]              srcBData,
  input  logic                       ldPushValid,
  input  logic [DW-1:0]              ldPushData,
  output logic                       ldFull,
  output logic [$clog2(DEPTH+1)-1:0] ldCount,
  input  logic                       stPopReady,
  output logic                       stValid,
  output logic                       stFull,
  output logic [DW-1:0]              stData,
  output logic [$clog2(DEPTH+1)-1:0] stCount
);
  localparam int NUM_REGS = (1 << CODE_W) - 1;

  logic [DW-1:0] regs [NUM_REGS];
  logic [DW-1:0] ldHead, ldNext, stNextUnused;
  logic          ldEmptyUnused, stEmpty;
  logic          ldAccept, stPop;

  assign ldAccept = ldPushValid && !ldFull;
  assign stPop    = stPopReady && !stEmpty;
  assign stValid  = !stEmpty;

  qorf_fifo #(.DW(DW), .DEPTH(DEPTH)) ldQueue (
    .clk(clk), .rst(rst),
    .pushEn(ldAccept), .pushData(ldPushData),
    .popCnt(strobes.ldPopCnt),
    .headData(ldHead), .nextData(ldNext),
    .count(ldCount), .full(ldFull), .empty(ldEmptyUnused)
  );

  qorf_fifo #(.DW(DW), .DEPTH(DEPTH)) stQueue (
    .clk(clk), .rst(rst),
    .pushEn(strobes.stPush), .pushData(wrData),
    .popCnt({1'b0, stPop}),
    .headData(stData), .nextData(stNextUnused),
    .count(stCount), .full(stFull), .empty(stEmpty)
  );

  always_comb begin
    srcAData = strobes.srcAQ ? ldHead : regs[srcACode];
    if (strobes.srcBQ) srcBData = strobes.srcAQ ? ldNext : ldHead;
    else               srcBData = regs[srcBCode];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NUM_REGS; i++) regs[i] <= '0;
    end else if (strobes.regWrite) begin
      regs[dstCode] <= wrData;
    end
  end
endmodule

// File: rtl/queue_operand_regfile.sv
module queue_operand_regfile
  import qorf_pkg::*;
#(
  parameter int DW     = 32,
  parameter int CODE_W = 5,
  parameter int DEPTH  = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              issueValid,
  input  logic              srcAEn,
  input  logic [CODE_W-1:0] srcACode,
  input  logic              srcBEn,
  input  logic [CODE_W-1:0] srcBCode,
  input  logic              wrEn,
  input  logic [CODE_W-1:0] dstCode,
  input  logic [DW-1:0]     wrData,
  output logic              stall,
  output logic [DW-1:0]     srcAData,
  output logic [DW-1:0]     srcBData,
  input  logic              ldPushValid,
  input  logic [DW-1:0]     ldPushData,
  output logic              ldFull,
  input  logic              stPopReady,
  output logic              stValid,
  output logic [DW-1:0]     stData
);
  localparam int CNT_W = $clog2(DEPTH+1);

  opStrobes_t       strobes;
  logic [CNT_W-1:0] ldCount;
  logic [CNT_W-1:0] stCount;
  logic             stFull;

  qorf_ctrl #(.CODE_W(CODE_W), .CNT_W(CNT_W), .DEPTH(DEPTH)) ctrl (
    .issueValid(issueValid),
    .srcAEn(srcAEn), .srcACode(srcACode),
    .srcBEn(srcBEn), .srcBCode(srcBCode),
    .wrEn(wrEn), .dstCode(dstCode),
    .ldCount(ldCount), .stFull(stFull),
    .stall(stall), .strobes(strobes)
  );

  qorf_datapath #(.DW(DW), .CODE_W(CODE_W), .DEPTH(DEPTH)) dp (
    .clk(clk), .rst(rst), .strobes(strobes),
    .srcACode(srcACode), .srcBCode(srcBCode), .dstCode(dstCode),
    .wrData(wrData), .srcAData(srcAData), .srcBData(srcBData),
    .ldPushValid(ldPushValid), .ldPushData(ldPushData),
    .ldFull(ldFull), .ldCount(ldCount),
    .stPopReady(stPopReady), .stValid(stValid), .stFull(stFull),
    .stData(stData), .stCount(stCount)
  );
endmodule

// File: rtl/qorf_checker.sv
module qorf_checker #(
  parameter int CODE_W = 5,
  parameter int DEPTH  = 8,
  parameter int CNT_W  = 4
) (
  input logic              clk,
  input logic              rst,
  input logic              issueValid,
  input logic              srcAEn,
  input logic [CODE_W-1:0] srcACode,
  input logic              srcBEn,
  input logic [CODE_W-1:0] srcBCode,
  input logic              wrEn,
  input logic [CODE_W-1:0] dstCode,
  input logic              stall,
  input logic              ldPushValid,
  input logic              ldFull,
  input logic              stPopReady,
  input logic              stValid,
  input logic [CNT_W-1:0]  ldCount,
  input logic [CNT_W-1:0]  stCount
);
  localparam logic [CODE_W-1:0] QCODE = '1;

  logic [CNT_W-1:0] ldGain, stLoss;
  assign ldGain = CNT_W'(ldPushValid && !ldFull);
  assign stLoss = CNT_W'(stPopReady && stValid);

  // R1
  reset_clear_chk: assert property (@(posedge clk) rst |=> (!stValid && !ldFull));

  // R5
  ld_empty_stall_chk: assert property (@(posedge clk) disable iff (rst)
    (issueValid && srcAEn && srcACode == QCODE && ldCount == '0) |-> stall);

  // R5
  ld_pair_stall_chk: assert property (@(posedge clk) disable iff (rst)
    (issueValid && srcAEn && srcBEn && srcACode == QCODE && srcBCode == QCODE
     && ldCount < CNT_W'(2)) |-> stall);

  // R7
  st_full_stall_chk: assert property (@(posedge clk) disable iff (rst)
    (issueValid && wrEn && dstCode == QCODE && stCount == CNT_W'(DEPTH)) |-> stall);

  // R8
  stall_ld_hold_chk: assert property (@(posedge clk) disable iff (rst)
    stall |=> ldCount == $past(ldCount) + $past(ldGain));

  // R8
  stall_st_hold_chk: assert property (@(posedge clk) disable iff (rst)
    stall |=> stCount == $past(stCount) - $past(stLoss));

  // R6
  st_source_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(stValid) |-> $past(issueValid && !stall && wrEn && dstCode == QCODE));

  // R9
  ld_bound_chk: assert property (@(posedge clk) disable iff (rst)
    ldCount <= CNT_W'(DEPTH));

  // R10
  idle_no_stall_chk: assert property (@(posedge clk) disable iff (rst)
    !issueValid |-> !stall);
endmodule

bind queue_operand_regfile qorf_checker #(.CODE_W(CODE_W), .DEPTH(DEPTH), .CNT_W(CNT_W)) qorfChk (
  .clk(clk), .rst(rst), .issueValid(issueValid),
  .srcAEn(srcAEn), .srcACode(srcACode), .srcBEn(srcBEn), .srcBCode(srcBCode),
  .wrEn(wrEn), .dstCode(dstCode), .stall(stall),
  .ldPushValid(ldPushValid), .ldFull(ldFull),
  .stPopReady(stPopReady), .stValid(stValid),
  .ldCount(ldCount), .stCount(stCount)
);

// File: tb/tb_queue_operand_regfile.sv
`timescale 1ns/1ps
module tb_queue_operand_regfile;
  localparam int QC = 31;
  localparam int QD = 8;

  logic        clk = 0;
  logic        rst = 1;
  logic        issueValid = 0, srcAEn = 0, srcBEn = 0, wrEn = 0;
  logic [4:0]  srcACode = 0, srcBCode = 0, dstCode = 0;
  logic [31:0] wrData = 0, ldPushData = 0;
  logic        ldPushValid = 0, stPopReady = 0;
  logic        stall, ldFull, stValid;
  logic [31:0] srcAData, srcBData, stData;

  int checks = 0;
  int errors = 0;

  logic [31:0] mRegs [31];
  logic [31:0] ldQ [$];
  logic [31:0] stQ [$];

  always #2 clk = ~clk;

  queue_operand_regfile dut (
    .clk(clk), .rst(rst), .issueValid(issueValid),
    .srcAEn(srcAEn), .srcACode(srcACode), .srcBEn(srcBEn), .srcBCode(srcBCode),
    .wrEn(wrEn), .dstCode(dstCode), .wrData(wrData), .stall(stall),
    .srcAData(srcAData), .srcBData(srcBData),
    .ldPushValid(ldPushValid), .ldPushData(ldPushData), .ldFull(ldFull),
    .stPopReady(stPopReady), .stValid(stValid), .stData(stData)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic expStall();
    int need;
    need = (srcAEn && srcACode == QC) + (srcBEn && srcBCode == QC);
    return issueValid && ((need > ldQ.size()) ||
                          (wrEn && dstCode == QC && stQ.size() == QD));
  endfunction

  // Called right after inputs are driven at the falling edge
  task automatic step(input string tag);
    logic es, fire, aQ, bQ;
    #1;
    es   = expStall();
    fire = issueValid && !es;
    aQ   = srcAEn && srcACode == QC;
    bQ   = srcBEn && srcBCode == QC;
    chk({"R5 R7 R10 stall ", tag}, stall, es);
    chk({"R9 ldFull ", tag}, ldFull, ldQ.size() == QD);
    chk({"R6 stValid ", tag}, stValid, stQ.size() != 0);
    if (stQ.size() != 0) chk({"R6 stData ", tag}, stData, stQ[0]);
    if (fire && srcAEn) begin
      if (aQ) chk({"R3 srcA queue ", tag}, srcAData, ldQ[0]);
      else    chk({"R2 srcA reg ", tag}, srcAData, mRegs[srcACode]);
    end
    if (fire && srcBEn) begin
      if (bQ) chk({"R4 srcB queue ", tag}, srcBData, aQ ? ldQ[1] : ldQ[0]);
      else    chk({"R2 srcB reg ", tag}, srcBData, mRegs[srcBCode]);
    end
    @(posedge clk);
    if (fire && aQ) void'(ldQ.pop_front());
    if (fire && bQ) void'(ldQ.pop_front());
    if (ldPushValid && ldQ.size() + ((fire && aQ) ? 1 : 0) + ((fire && bQ) ? 1 : 0) < QD + 1
        && !(ldQ.size() + ((fire && aQ) ? 1 : 0) + ((fire && bQ) ? 1 : 0) == QD))
      ldQ.push_back(ldPushData);
    if (stPopReady && stQ.size() != 0) void'(stQ.pop_front());
    if (fire && wrEn) begin
      if (dstCode == QC) stQ.push_back(wrData);
      else               mRegs[dstCode] = wrData;
    end
    @(negedge clk);
  endtask

  task automatic drive(input logic iv, input logic ae, input int a, input logic be, input int b,
                       input logic we, input int d, input logic [31:0] wd,
                       input logic lp, input logic [31:0] ld, input logic sp);
    issueValid = iv; srcAEn = ae; srcACode = 5'(a); srcBEn = be; srcBCode = 5'(b);
    wrEn = we; dstCode = 5'(d); wrData = wd;
    ldPushValid = lp; ldPushData = ld; stPopReady = sp;
  endtask

  initial begin
    #(4 * 200000);
    errors++;
    $display("FAIL watchdog actual %h expected %h", 0, 1);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    for (int i = 0; i < 31; i++) mRegs[i] = '0;
    repeat (3) @(negedge clk);
    rst = 0;

    // R1: reset state, all registers read zero
    chk("R1 stValid after reset", stValid, 0);
    chk("R1 ldFull after reset", ldFull, 0);
    for (int r = 0; r < 31; r += 2) begin
      drive(1, 1, r, 1, r + 1 > 30 ? 0 : r + 1, 0, 0, 0, 0, 0, 0);
      step("R1 reset read");
    end

    // R2: same-cycle write and read of one register returns old value
    drive(1, 1, 3, 0, 0, 1, 3, 32'hAAAA_0003, 0, 0, 0); step("R2 write");
    drive(1, 1, 3, 1, 3, 1, 3, 32'hBBBB_0003, 0, 0, 0); step("R2 same cycle");
    drive(1, 1, 3, 0, 0, 0, 0, 0, 0, 0, 0); step("R2 after");

    // R5 R8: empty load queue stalls and suppresses register write
    drive(1, 1, QC, 0, 0, 1, 5, 32'hDEAD_0005, 0, 0, 0); step("R5 R8 stalled");
    drive(1, 1, 5, 0, 0, 0, 0, 0, 0, 0, 0); step("R8 reg unchanged");

    // R10: no issue, queue code read without data, nothing changes
    drive(0, 1, QC, 1, QC, 1, QC, 32'h1, 0, 0, 0); step("R10 idle");

    // R9: push nine words, ninth dropped
    for (int k = 0; k < 9; k++) begin
      drive(0, 0, 0, 0, 0, 0, 0, 0, 1, 32'h1000_0000 + k, 0);
      step("R9 fill");
    end
    drive(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0); step("R9 full");

    // R4: paired pops, then drain to one word and try a pair
    for (int k = 0; k < 3; k++) begin
      drive(1, 1, QC, 1, QC, 0, 0, 0, 0, 0, 0); step("R4 pair");
    end
    drive(1, 1, QC, 0, 0, 0, 0, 0, 0, 0, 0); step("R3 single");
    drive(1, 1, QC, 1, QC, 0, 0, 0, 0, 0, 0); step("R5 pair with one");
    drive(1, 0, 0, 1, QC, 0, 0, 0, 0, 0, 0); step("R3 source B alone");

    // R7: fill store queue, then a push while full with memory popping
    for (int k = 0; k < 9; k++) begin
      drive(1, 0, 0, 0, 0, 1, QC, 32'h2000_0000 + k, 0, 0, 0);
      step("R7 fill");
    end
    drive(1, 0, 0, 0, 0, 1, QC, 32'h2FFF_FFFF, 0, 0, 1); step("R7 full pop");
    for (int k = 0; k < 9; k++) begin
      drive(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 1); step("R6 drain");
    end

    // Random traffic
    for (int n = 0; n < 4000; n++) begin
      int a, b, d;
      a = ($urandom % 4 == 0) ? QC : $urandom % 31;
      b = ($urandom % 4 == 0) ? QC : $urandom % 31;
      d = ($urandom % 5 == 0) ? QC : $urandom % 31;
      drive($urandom % 4 != 0, $urandom % 2, a, $urandom % 2, b,
            $urandom % 2, d, $urandom, $urandom % 2, $urandom, $urandom % 3 == 0);
      step("random");
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule